// File: doc/BRIEF.md
# Table-Seeded Newton-Raphson Significand Divider

This block divides one normalized significand by another. Both operands are unsigned fixed-point values with one integer bit and seventeen fraction bits, and both lie between 1.0 and just under 2.0. The divider does not use a long-division loop. It reads a first reciprocal estimate for the divisor from a small table, improves that estimate with a single Newton-Raphson step, x1 = x0 * (2 - d * x0), and multiplies the dividend by the improved reciprocal. The table is computed when the design is elaborated. It is indexed by the divisor fraction bits just below the leading one, and each entry holds the reciprocal of the midpoint of its interval.

A single multiplier is shared across the three products. A control sequence feeds it in turn, so a result appears a fixed number of cycles after a start. The raw quotient lies between 0.5 and 2.0. When the dividend is smaller than the divisor, the quotient is doubled and an adjust flag asks the surrounding datapath to lower the result exponent by one. That datapath also handles signs, exponents and zero operands.

Top module: `nr_recip_div`

## Requirements
- R1: While reset is held, and directly after it is released, done, quotient and exp_dec are all 0.
- R2: A start that is sampled high while the block is idle is accepted. done is then high for exactly one cycle, four clock edges after the edge that accepted the start.
- R3: A start raised while a division is in progress has no effect. The pending result keeps its operands and its timing, and no extra done pulse follows.
- R4: When done is high, the result lies within 2 LSB of the exactly rounded quotient. The result value is quotient/2^17 when exp_dec is 0 and quotient/2^18 when exp_dec is 1.
- R5: exp_dec is 1 exactly when the dividend is smaller than the divisor. In that case quotient carries twice the true quotient.
- R6: When done is high, bit 17 of quotient is 1, so the result is normalized to the range 1.0 to 2.0.
- R7: Equal dividend and divisor give exactly 1.0 (quotient 0x20000) with exp_dec 0.
- R8: quotient and exp_dec change only on the cycle where done is high. Between done pulses they hold their values, whatever happens on the operand inputs.
- R9: A start raised in the same cycle that done is high is accepted. The next done then follows four edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a division when the block is idle |
| dividend | input | 18 | Dividend significand, unsigned 1.17, bit 17 set |
| divisor | input | 18 | Divisor significand, unsigned 1.17, bit 17 set |
| quotient | output | 18 | Normalized quotient significand, unsigned 1.17 |
| exp_dec | output | 1 | 1 when the quotient was doubled and the exponent must drop by one |
| done | output | 1 | One-cycle pulse marking a new valid quotient |

## Verification
The delivery of one result and the acceptance of the next division can fall in the same cycle. The bench provokes this by raising start on the exact cycle where done is high. It then checks that the first quotient is correct and stays on the outputs. It also checks that the second division completes four edges later with its own correct quotient. A start raised in the middle of a division tests the other side of the same rule. That start must not disturb the pending result or create an extra done pulse.

// File: rtl/nrr_pkg.sv
package nrr_pkg;

    // Significand width (1 integer bit + fraction bits)
    localparam int SIG_W  = 18;
    localparam int FRAC_W = SIG_W - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_STEP_A,
        ST_STEP_B,
        ST_FINAL
    } nrr_state_e;

    typedef struct packed {
        logic [SIG_W-1:0] quo;
        logic             dec;
    } nrr_result_t;

    // Rounded reciprocal of interval midpoint, scaled by 2^rw.
    // Midpoint = (2^(idx_w+1) + 2*idx + 1) / 2^(idx_w+1).
    function automatic logic [63:0] seed_of(input int idx, input int idx_w, input int rw);
        logic [63:0] num;
        logic [63:0] den;
        num = 64'(1) << (rw + idx_w + 2);
        den = (64'(1) << (idx_w + 1)) + 64'(2 * idx + 1);
        return ((num / den) + 64'd1) >> 1;
    endfunction

endpackage

// File: rtl/nrr_seed_rom.sv
module nrr_seed_rom #(
    parameter int IDX_W = 8,
    parameter int RW    = 24
) (
    input  logic             clk,
    input  logic [IDX_W-1:0] addr,
    output logic [RW-1:0]    seed
);
    import nrr_pkg::*;

    localparam int DEPTH = 1 << IDX_W;

    logic [RW-1:0] ent_w [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        assign ent_w[g] = RW'(seed_of(g, IDX_W, RW));
    end

    always_ff @(posedge clk) begin
        seed <= ent_w[addr];
    end

endmodule

// File: rtl/nrr_mul.sv
module nrr_mul #(
    parameter int W = 24
) (
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    output logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;

    assign prod = PW'(op_a) * PW'(op_b);

endmodule

// File: rtl/nrr_norm.sv
module nrr_norm
    import nrr_pkg::*;
#(
    parameter int RW = 24
) (
    input  logic [2*RW-1:0] prod,   // dividend * reciprocal, scale 2^(FRAC_W+RW)
    input  logic            less,   // dividend below divisor
    output nrr_result_t     res
);
    localparam int PW = 2 * RW;

    logic [PW:0] rnd_hi;
    logic [PW:0] rnd_lo;
    logic [PW:0] val;

    always_comb begin
        rnd_hi = {1'b0, prod} + ((PW+1)'(1) << (RW - 1));
        rnd_lo = {1'b0, prod} + ((PW+1)'(1) << (RW - 2));
        val    = less ? (rnd_lo >> (RW - 1)) : (rnd_hi >> RW);
        res.dec = less;
        if (val < ((PW+1)'(1) << FRAC_W)) begin
            res.quo = SIG_W'(1) << FRAC_W;
        end else if (val >= ((PW+1)'(1) << SIG_W)) begin
            res.quo = '1;
        end else begin
            res.quo = val[SIG_W-1:0];
        end
    end

endmodule

// File: rtl/nr_recip_div.sv
module nr_recip_div
    import nrr_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int GUARD = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [SIG_W-1:0] dividend,
    input  logic [SIG_W-1:0] divisor,
    output logic [SIG_W-1:0] quotient,
    output logic             exp_dec,
    output logic             done
);
    localparam int RW      = SIG_W + GUARD;      // reciprocal width
    localparam int PW      = 2 * RW;             // product width
    localparam int ONE_POS = FRAC_W + RW;        // weight of 1.0 in d*x0
    localparam int Y_SH    = ONE_POS - (RW - 1); // shift to 1.(RW-1)

    nrr_state_e       state;
    logic [SIG_W-1:0] a_q;
    logic [SIG_W-1:0] d_q;
    logic [RW-1:0]    x0;
    logic [RW-1:0]    y_q;
    logic [RW-1:0]    x1_q;
    nrr_result_t      res_q;
    logic             done_q;
    logic             accept;

    logic [RW-1:0]    op_a;
    logic [RW-1:0]    op_b;
    logic [PW-1:0]    prod;
    logic [PW-1:0]    y_full;
    logic [PW-1:0]    y_rnd;
    logic [RW-1:0]    y_next;
    logic [RW:0]      x1_wide;
    logic [RW-1:0]    x1_next;
    nrr_result_t      norm_res;
    logic             unused_bits;

    assign accept = start && (state == ST_IDLE);

    // Seed table, registered read during the look-up cycle
    nrr_seed_rom #(.IDX_W(IDX_W), .RW(RW)) u_rom (
        .clk  (clk),
        .addr (d_q[FRAC_W-1 -: IDX_W]),
        .seed (x0)
    );

    // Shared multiplier operand selection
    always_comb begin
        unique case (state)
            ST_STEP_A: begin op_a = RW'(d_q); op_b = x0;   end
            ST_STEP_B: begin op_a = x0;       op_b = y_q;  end
            default:   begin op_a = RW'(a_q); op_b = x1_q; end
        endcase
    end

    nrr_mul #(.W(RW)) u_mul (
        .op_a (op_a),
        .op_b (op_b),
        .prod (prod)
    );

    // Correction term 2 - d*x0, rounded to 1.(RW-1)
    always_comb begin
        y_full = (PW'(1) << (ONE_POS + 1)) - prod;
        y_rnd  = y_full + (PW'(1) << (Y_SH - 1));
        y_next = y_rnd[Y_SH +: RW];
    end

    // Refined reciprocal x0*y, truncated to 0.RW with saturation
    always_comb begin
        x1_wide = prod[RW-1 +: RW+1];
        x1_next = x1_wide[RW] ? '1 : x1_wide[RW-1:0];
    end

    assign unused_bits = ^{y_rnd[Y_SH-1:0], y_rnd[PW-1:Y_SH+RW], prod[RW-2:0]};

    nrr_norm #(.RW(RW)) u_norm (
        .prod (prod),
        .less (a_q < d_q),
        .res  (norm_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            a_q    <= '0;
            d_q    <= '0;
            y_q    <= '0;
            x1_q   <= '0;
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        a_q   <= dividend;
                        d_q   <= divisor;
                        state <= ST_LOOK;
                    end
                end
                ST_LOOK:   state <= ST_STEP_A;
                ST_STEP_A: begin
                    y_q   <= y_next;
                    state <= ST_STEP_B;
                end
                ST_STEP_B: begin
                    x1_q  <= x1_next;
                    state <= ST_FINAL;
                end
                ST_FINAL: begin
                    res_q  <= norm_res;
                    done_q <= 1'b1;
                    state  <= ST_IDLE;
                end
                default:   state <= ST_IDLE;
            endcase
        end
    end

    assign quotient = res_q.quo;
    assign exp_dec  = res_q.dec;
    assign done     = done_q;

    // R2
    done_lat_chk: assert property (@(posedge clk) disable iff (rst)
        $past(accept, 4) |=> done);

    // R2
    done_src_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(accept, 5));

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (start && (state != ST_IDLE)) |=> ($stable(a_q) && $stable(d_q)));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(quotient) |-> done);

    // R6
    lead_one_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> quotient[SIG_W-1]);

    // R5
    adjust_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (exp_dec == (a_q < d_q)));

endmodule

// File: tb/test_nr_recip_div.sv
module test_nr_recip_div;
    import nrr_pkg::*;

    localparam int W = SIG_W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic [W-1:0] quotient;
    logic         exp_dec;
    logic         done;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    nr_recip_div i_nr_recip_div (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .dividend (dividend),
        .divisor  (divisor),
        .quotient (quotient),
        .exp_dec  (exp_dec),
        .done     (done)
    );

    function automatic int ref_quo(input logic [W-1:0] a, input logic [W-1:0] d);
        logic [63:0] num;
        logic [63:0] r;
        num = (a >= d) ? (64'(a) << FRAC_W) : (64'(a) << W);
        r   = (64'd2 * num + 64'(d)) / (64'd2 * 64'(d));
        if (r > 64'((1 << W) - 1)) r = 64'((1 << W) - 1);
        return int'(r);
    endfunction

    task automatic expect_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic expect_near(input string tag, input int act, input int exp, input int tol);
        int diff;
        diff = act - exp;
        if (diff < 0) diff = -diff;
        n_chk++;
        if (diff > tol) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h (+/-%0d)", tag, act, exp, tol);
        end
    endtask

    // Raise start on the current negedge, drop it after the next edge
    task automatic drive_start(input logic [W-1:0] a, input logic [W-1:0] d);
        start    = 1'b1;
        dividend = a;
        divisor  = d;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic launch(input logic [W-1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        drive_start(a, d);
    endtask

    // Called one negedge after the accepting edge; ends in the done cycle
    task automatic wait_result(input logic [W-1:0] a, input logic [W-1:0] d, input string tag);
        repeat (3) @(negedge clk);
        expect_eq({tag, " R2 done early"}, int'(done), 0);
        @(negedge clk);
        expect_eq({tag, " R2 done"}, int'(done), 1);
        expect_eq({tag, " R5 exp_dec"}, int'(exp_dec), int'(a < d));
        expect_near({tag, " R4 quotient"}, int'(quotient), ref_quo(a, d), 2);
        expect_eq({tag, " R6 lead"}, int'(quotient[W-1]), 1);
        if (a == d) expect_eq({tag, " R7 unity"}, int'(quotient), 32'h20000);
    endtask

    task automatic run_one(input logic [W-1:0] a, input logic [W-1:0] d, input string tag);
        launch(a, d);
        wait_result(a, d, tag);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL R2 watchdog: actual hung expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] ra;
        logic [W-1:0] rd;
        logic [W-1:0] hq;
        logic         he;
        bit           extra;

        void'($urandom(32'd20240611));

        // R1: reset state
        repeat (4) @(negedge clk);
        expect_eq("R1 done in reset", int'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        expect_eq("R1 done", int'(done), 0);
        expect_eq("R1 quotient", int'(quotient), 0);
        expect_eq("R1 exp_dec", int'(exp_dec), 0);

        // Directed corners
        run_one(18'h20000, 18'h20000, "one/one");
        run_one(18'h3FFFF, 18'h3FFFF, "max/max");
        run_one(18'h3FFFF, 18'h20000, "max/one");
        run_one(18'h20000, 18'h3FFFF, "one/max");
        run_one(18'h20000, 18'h20001, "one/one+lsb");
        run_one(18'h20001, 18'h20000, "one+lsb/one");
        run_one(18'h30000, 18'h20000, "1.5/one");
        run_one(18'h20000, 18'h30000, "one/1.5");

        // Table interval edges
        for (int k = 1; k < 256; k += 17) begin
            run_one(18'h2ABCD, 18'h20000 | 18'(k << 9), "edge lo");
            run_one(18'h35555, 18'h20000 | 18'((k << 9) - 1), "edge hi");
        end

        // R3: start during a busy division is ignored
        launch(18'h2C000, 18'h24000);
        @(negedge clk);
        drive_start(18'h3F000, 18'h21000);
        @(negedge clk);
        expect_eq("R3 done early", int'(done), 0);
        @(negedge clk);
        expect_eq("R3 done", int'(done), 1);
        expect_near("R3 quotient", int'(quotient), ref_quo(18'h2C000, 18'h24000), 2);
        extra = 1'b0;
        repeat (7) begin
            @(negedge clk);
            if (done) extra = 1'b1;
        end
        expect_eq("R3 no extra done", int'(extra), 0);

        // R8: outputs hold while inputs wander without start
        run_one(18'h23456, 18'h3789A, "pre-hold");
        hq = quotient;
        he = exp_dec;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            dividend = {1'b1, 17'($urandom)};
            divisor  = {1'b1, 17'($urandom)};
        end
        expect_eq("R8 quotient held", int'(quotient), int'(hq));
        expect_eq("R8 exp_dec held", int'(exp_dec), int'(he));

        // R9: start in the done cycle
        run_one(18'h31111, 18'h28888, "b2b first");
        drive_start(18'h21234, 18'h3EEEE);
        expect_near("R9 first kept", int'(quotient), ref_quo(18'h31111, 18'h28888), 2);
        wait_result(18'h21234, 18'h3EEEE, "R9 second");

        // Random operands, including near-equal pairs
        for (int i = 0; i < 400; i++) begin
            ra = {1'b1, 17'($urandom)};
            case (i % 8)
                0:       rd = ra;
                1:       rd = (ra == 18'h3FFFF) ? ra : ra + 18'd1;
                2:       rd = (ra == 18'h20000) ? ra : ra - 18'd1;
                default: rd = {1'b1, 17'($urandom)};
            endcase
            run_one(ra, rd, "random");
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule